// File: doc/BRIEF.md
# Overcharge Protection Delay Controller

This block is the charge-side control logic of a two-cell battery protector. Comparators outside the block reduce every cell voltage and the charger-minus node to synchronous flags. The block times those flags against a 1 kHz tick. It opens the charge path (`chg_en` low) once an overcharge flag has held for the detect delay. It closes the path again once every cell has been under the release threshold for the release delay. The release threshold depends on what is attached. With a charger present, every cell must be under the low release threshold. With a load present, every cell need only be under the high release threshold. This removes most of the detect hysteresis when a load drains the pack through the body diode of the charge switch.

`ovc_active` is high for as long as the overcharge condition is held, including the release wait. The discharge controller uses it to hold off overcurrent detection. A zero-volt-charge request forces `chg_en` high and does not disturb the timing state. The test pin shortens both delays to the normal tick count shifted right by `TEST_SHIFT`, with a floor of one tick.

The controller has four states:
- **IDLE**: charging is allowed.
- **DET_WAIT**: the detect delay is running.
- **TRIPPED**: charging is blocked.
- **REL_WAIT**: the release delay is running.

The state transitions are:
- **IDLE→DET_WAIT**: any overcharge flag is high.
- **DET_WAIT→IDLE**: every overcharge flag is low.
- **DET_WAIT→TRIPPED**: the detect timer finishes.
- **TRIPPED→REL_WAIT**: the release condition holds.
- **REL_WAIT→TRIPPED**: the release condition fails.
- **REL_WAIT→IDLE**: the release timer finishes.

Top module: `ovp_charge_ctrl`

## Requirements
- R1: Once any bit of `ovc_det` is high in IDLE, the state moves to DET_WAIT on the next clock. `chg_en` then falls on the edge that delivers the detect-limit-th `tick` counted in DET_WAIT, and not one tick earlier.
- R2: If every `ovc_det` bit drops during DET_WAIT, the state returns to IDLE and the tick count restarts from zero. A later attempt needs the full detect delay again.
- R3: With `load_present` low, the release condition is that every bit of `rel_lo` is high. Bit i of `rel_lo` means cell i is at or below the low release threshold.
- R4: With `load_present` high, the release condition is that every bit of `rel_hi` is high. Bit i of `rel_hi` means cell i is at or below the high release threshold.
- R5: In TRIPPED, `chg_en` stays low while the release condition fails. Once the condition is met it must hold for the release-limit count of ticks, and `chg_en` rises on the last of them. A drop in the condition returns the state to TRIPPED and restarts the count.
- R6: `ovc_active` is high in TRIPPED and REL_WAIT, and low in IDLE and DET_WAIT.
- R7: While `zv_chg_en` is high, `chg_en` is high. `ovc_active` and the timing state are unaffected.
- R8: With `test_mode` high, the detect limit is DET_TICKS>>TEST_SHIFT and the release limit is REL_TICKS>>TEST_SHIFT, each raised to 1 if the shift gives 0. With `test_mode` low, the limits are DET_TICKS and REL_TICKS.
- R9: During and right after reset, `chg_en` is high, `ovc_active` is low and the tick count is zero.
- R10: Only clock cycles with `tick` high advance a delay. With no tick, no state change ends a delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 1 kHz timebase pulse |
| ovc_det | input | NCELL | Per-cell overcharge flag |
| rel_lo | input | NCELL | Per-cell flag: cell at or below the low release threshold |
| rel_hi | input | NCELL | Per-cell flag: cell at or below the high release threshold |
| load_present | input | 1 | Charger-minus node above the overcurrent threshold |
| zv_chg_en | input | 1 | Zero-volt charge request |
| test_mode | input | 1 | Shortened-delay mode |
| chg_en | output | 1 | Active-high charge switch enable |
| ovc_active | output | 1 | Overcharge state held; suppress overcurrent detection |

## Verification
The checker assumes that `tick` is a one-cycle pulse and that `test_mode` is steady for as long as a detect delay runs. Its delay bound is only meaningful under that assumption. It also assumes that every input is synchronous to `clk`. The stimulus changes inputs only on falling edges and raises `tick` for one cycle at a time. It sets `test_mode` only between resets. The release sweep drives all sixteen combinations of the per-cell release flags, including combinations that are physically inconsistent, so the threshold selection is checked on its own logic.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DET_WAIT = 2'd1,
        ST_TRIPPED  = 2'd2,
        ST_REL_WAIT = 2'd3
    } ovp_state_t;

    // Tick limit for one delay, shortened in test mode with a floor of one.
    function automatic int unsigned delay_limit(int unsigned ticks,
                                                int unsigned shift,
                                                logic        shorten);
        int unsigned s;
        s = ticks >> shift;
        if (!shorten)   return ticks;
        if (s == 0)     return 1;
        return s;
    endfunction

endpackage

// File: rtl/ovp_tick_timer.sv
module ovp_tick_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run || done) cnt <= '0;
        else if (tick)       cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/ovp_release_sel.sv
module ovp_release_sel #(
    parameter int NCELL = 2
) (
    input  logic [NCELL-1:0] rel_lo,
    input  logic [NCELL-1:0] rel_hi,
    input  logic             load_present,
    output logic             rel_ok
);
    logic [NCELL-1:0] cell_ok;

    // Each cell picks the threshold that matches the attached equipment.
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        assign cell_ok[i] = load_present ? rel_hi[i] : rel_lo[i];
    end

    assign rel_ok = &cell_ok;
endmodule

// File: rtl/ovp_charge_ctrl.sv
module ovp_charge_ctrl
    import ovp_pkg::*;
#(
    parameter int NCELL      = 2,
    parameter int DET_TICKS  = 1000,
    parameter int REL_TICKS  = 40,
    parameter int TEST_SHIFT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NCELL-1:0] ovc_det,
    input  logic [NCELL-1:0] rel_lo,
    input  logic [NCELL-1:0] rel_hi,
    input  logic             load_present,
    input  logic             zv_chg_en,
    input  logic             test_mode,
    output logic             chg_en,
    output logic             ovc_active
);
    localparam int MAXT = (DET_TICKS > REL_TICKS) ? DET_TICKS : REL_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    ovp_state_t    state, state_nx;
    logic          any_ovc, rel_ok, t_run, t_done;
    logic [CW-1:0] det_lim, rel_lim, t_lim;

    assign any_ovc = |ovc_det;
    assign det_lim = CW'(delay_limit(DET_TICKS, TEST_SHIFT, test_mode));
    assign rel_lim = CW'(delay_limit(REL_TICKS, TEST_SHIFT, test_mode));

    ovp_release_sel #(.NCELL(NCELL)) u_rel (
        .rel_lo       (rel_lo),
        .rel_hi       (rel_hi),
        .load_present (load_present),
        .rel_ok       (rel_ok)
    );

    // One shared timer: only one delay can run at a time.
    always_comb begin
        t_run = 1'b0;
        t_lim = det_lim;
        unique case (state)
            ST_DET_WAIT: begin t_run = any_ovc; t_lim = det_lim; end
            ST_REL_WAIT: begin t_run = rel_ok;  t_lim = rel_lim; end
            default:     begin t_run = 1'b0;    t_lim = det_lim; end
        endcase
    end

    ovp_tick_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t_run),
        .tick  (tick),
        .limit (t_lim),
        .done  (t_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (any_ovc) state_nx = ST_DET_WAIT;
            ST_DET_WAIT: if (!any_ovc)     state_nx = ST_IDLE;
                         else if (t_done)  state_nx = ST_TRIPPED;
            ST_TRIPPED:  if (rel_ok)  state_nx = ST_REL_WAIT;
            ST_REL_WAIT: if (!rel_ok)      state_nx = ST_TRIPPED;
                         else if (t_done)  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_TRIPPED, ST_REL_WAIT: ovc_active = 1'b1;
            default:                 ovc_active = 1'b0;
        endcase
        chg_en = zv_chg_en || !ovc_active;
    end
endmodule

// File: rtl/ovp_charge_ctrl_chk.sv
module ovp_charge_ctrl_chk #(
    parameter int NCELL     = 2,
    parameter int DET_TICKS = 1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [NCELL-1:0] ovc_det,
    input logic [NCELL-1:0] rel_lo,
    input logic [NCELL-1:0] rel_hi,
    input logic             load_present,
    input logic             zv_chg_en,
    input logic             test_mode,
    input logic             chg_en,
    input logic             ovc_active
);
    localparam int HW = $clog2(DET_TICKS + 1) + 1;
    logic [HW-1:0] hold_cnt;

    // Ticks seen while some overcharge flag stays high before the trip.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       hold_cnt <= '0;
        else if (!(|ovc_det) || ovc_active) hold_cnt <= '0;
        else if (tick && !(&hold_cnt))    hold_cnt <= hold_cnt + HW'(1);
    end

    p_reset_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chg_en && !ovc_active));

    p_trip_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovc_active) |-> ($past(|ovc_det) && $past(tick)));

    p_trip_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovc_active) && !$past(test_mode)) |->
            (int'($past(hold_cnt)) >= DET_TICKS - 1));

    p_release_charger_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovc_active) && !$past(load_present)) |-> $past(&rel_lo));

    p_release_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovc_active) && $past(load_present)) |-> $past(&rel_hi));

    p_release_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovc_active) |-> $past(tick));

    p_zero_volt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zv_chg_en |-> chg_en);

    p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en |-> ovc_active);
endmodule

bind ovp_charge_ctrl ovp_charge_ctrl_chk #(.NCELL(NCELL), .DET_TICKS(DET_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .ovc_det      (ovc_det),
    .rel_lo       (rel_lo),
    .rel_hi       (rel_hi),
    .load_present (load_present),
    .zv_chg_en    (zv_chg_en),
    .test_mode    (test_mode),
    .chg_en       (chg_en),
    .ovc_active   (ovc_active)
);

// File: tb/ovp_charge_ctrl_test.sv
module ovp_charge_ctrl_test;
    localparam int NC  = 2;
    localparam int DET = 10;
    localparam int REL = 3;
    localparam int SH  = 2;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic [NC-1:0] ovc_det = '0, rel_lo = '0, rel_hi = '0;
    logic load_present = 1'b0, zv_chg_en = 1'b0, test_mode = 1'b0;
    logic chg_en, ovc_active;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ovp_charge_ctrl #(.NCELL(NC), .DET_TICKS(DET), .REL_TICKS(REL), .TEST_SHIFT(SH)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ovc_det(ovc_det),
        .rel_lo(rel_lo), .rel_hi(rel_hi), .load_present(load_present),
        .zv_chg_en(zv_chg_en), .test_mode(test_mode),
        .chg_en(chg_en), .ovc_active(ovc_active)
    );

    function automatic int lim(int n, logic t);
        int s = n >> SH;
        if (!t) return n;
        return (s < 1) ? 1 : s;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic do_reset(logic t);
        @(negedge clk);
        rst_n = 1'b0; ovc_det = '0; rel_lo = '0; rel_hi = '0;
        load_present = 1'b0; zv_chg_en = 1'b0; tick = 1'b0; test_mode = t;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic trip(logic t);
        do_reset(t);
        ovc_det = 2'b01; idle(1);
        ticks(lim(DET, t));
        ovc_det = '0; idle(1);
    endtask

    initial begin
        // R9: reset state
        do_reset(1'b0);
        check("R9 chg_en after reset", chg_en, 1'b1);
        check("R9 ovc_active after reset", ovc_active, 1'b0);

        // R1 / R8 / R6: detect delay for every flag pattern, both modes
        for (int t = 0; t < 2; t++) begin
            for (int p = 1; p < 4; p++) begin
                do_reset(t[0]);
                ovc_det = p[1:0]; idle(1);
                ticks(lim(DET, t[0]) - 1);
                check(t ? "R8 detect not early" : "R1 detect not early", chg_en, 1'b1);
                check("R6 inactive in DET_WAIT", ovc_active, 1'b0);
                ticks(1);
                check(t ? "R8 detect at limit" : "R1 detect at limit", chg_en, 1'b0);
                check("R6 active when tripped", ovc_active, 1'b1);
            end
        end

        // R10: no ticks, no trip
        do_reset(1'b0);
        ovc_det = 2'b11; idle(3 * DET);
        check("R10 no tick keeps chg_en", chg_en, 1'b1);

        // R2: glitch restarts the detect count
        do_reset(1'b0);
        ovc_det = 2'b10; idle(1);
        ticks(DET - 1);
        ovc_det = '0; idle(1);
        ovc_det = 2'b10; idle(1);
        ticks(DET - 1);
        check("R2 restart after drop", chg_en, 1'b1);
        ticks(1);
        check("R2 trip after full delay", chg_en, 1'b0);

        // R3 / R4: release threshold selection, all flag combinations
        for (int ld = 0; ld < 2; ld++) begin
            for (int c = 0; c < 16; c++) begin
                logic exp;
                trip(1'b0);
                load_present = ld[0];
                rel_lo = c[1:0]; rel_hi = c[3:2];
                exp = ld ? (c[3:2] == 2'b11) : (c[1:0] == 2'b11);
                idle(1);
                ticks(REL);
                check(ld ? "R4 load release chg_en" : "R3 charger release chg_en", chg_en, exp);
                check(ld ? "R4 load release ovc_active" : "R3 charger release ovc_active",
                      ovc_active, !exp);
            end
        end

        // R5: release count restarts when the condition drops
        trip(1'b0);
        rel_lo = 2'b11; rel_hi = 2'b11; idle(1);
        ticks(REL - 1);
        check("R5 no early release", chg_en, 1'b0);
        rel_lo = 2'b01; idle(1);
        ticks(REL);
        check("R5 held low while unmet", chg_en, 1'b0);
        rel_lo = 2'b11; idle(1);
        ticks(REL - 1);
        check("R5 restarted count", chg_en, 1'b0);
        ticks(1);
        check("R5 release at limit", chg_en, 1'b1);

        // R7: zero-volt request overrides output only
        trip(1'b0);
        zv_chg_en = 1'b1; idle(1);
        check("R7 forced chg_en", chg_en, 1'b1);
        check("R7 state kept", ovc_active, 1'b1);
        zv_chg_en = 1'b0; idle(1);
        check("R7 back to blocked", chg_en, 1'b0);

        // R8: shortened release floors at one tick
        trip(1'b1);
        load_present = 1'b1; rel_hi = 2'b11; idle(1);
        check("R8 not released before tick", chg_en, 1'b0);
        ticks(1);
        check("R8 one-tick release", chg_en, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule